// File: doc/BRIEF.md
# Reconfigurable Timer/Counter with Capture

This block holds two 8-bit counting halves and one 8-bit prescaler. A two-bit mode field joins or splits them. The four arrangements are: two separate prescaled timers; a prescaled timer in the low half beside an event counter in the high half; one cascaded 16-bit prescaled timer; and one 16-bit event counter that bypasses the prescaler. Each half compares its count with a match value. When it reaches that value it returns to zero on its next counting tick and raises an interrupt flag.

Software reaches the block through a simple register port. Writes are synchronous. Reads are combinational from a read address. The event input and both capture strobe inputs each pass through a two-flop synchroniser and a rising-edge detector before the block uses them. A capture strobe copies the live count into a capture register. In the 16-bit modes one strobe copies the whole count in a single edge, so the two halves can never disagree.

Top module: `multiModeTimer`

## Requirements
- R1: After reset the control register reads 0, the prescaler reload reads 0, both match registers read 0xFF, both counts and both capture registers read 0, and irqLo and irqHi are low.
- R2: The register addresses are: 0 control, 1 prescaler reload, 2 low match, 3 high match, 4 low count, 5 high count, 6 low capture, 7 high capture. The control write bits are: [1:0] mode, [2] run, [3] restart (not stored), [4] clear low flag, [5] clear high flag. A control read returns [7] high flag, [6] low flag, [2] run and [1:0] mode. Bits [5:3] read as zero.
- R3: With reload value P and run set, the prescaler issues one tick every P+1 clock cycles. With run clear, no counter changes except through restart.
- R4: A write to the prescaler reload takes effect at the next prescaler terminal count. A restart loads it at once.
- R5: In mode 0 each half counts prescaler ticks on its own. A half that is at its match value goes to 0 on its next tick and sets its own flag.
- R6: In mode 1 the low half counts prescaler ticks and the high half counts event edges. Each half has its own match value and flag.
- R7: In mode 2 the halves form one 16-bit counter of prescaler ticks. When the count reaches the 16-bit match value it goes to 0 on the next tick and sets irqHi. irqLo is never set in this mode.
- R8: In mode 3 the halves form one 16-bit counter of event edges. It wraps and flags as in R7, and the prescaler has no influence on it.
- R9: Each rising edge of the event input counts once, provided the input stays high and then low for at least one clock each. A level held high for many cycles counts once.
- R10: In modes 0 and 1 a rising edge on capLoIn copies the low count into the low capture register. A rising edge on capHiIn copies the high count into the high capture register.
- R11: In modes 2 and 3 a rising edge on capLoIn copies both halves at once. capHiIn is ignored.
- R12: Writing control with bit 4 or bit 5 set clears the low or high flag. The other flag is left unchanged.
- R13: Writing control with bit 3 set clears both counts and the prescaler on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Combinational read data |
| evtIn | input | 1 | External event input (asynchronous) |
| capLoIn | input | 1 | Low-half / 16-bit capture strobe (asynchronous) |
| capHiIn | input | 1 | High-half capture strobe (asynchronous) |
| irqLo | output | 1 | Low-half interrupt flag |
| irqHi | output | 1 | High-half or 16-bit interrupt flag |

## Verification
The hardest condition to reach from the ports is the deferred prescaler reload. A new reload value must be written while the prescaler is partway through a period, and the bench must then show that the old period finishes before the new one starts. The bench does this by writing the new value one cycle after a restart. It then counts ticks over a window whose length gives different totals for three cases: deferred, immediate and ignored reload. Capture values are made deterministic by stopping the counters before the strobe arrives. The ignored high strobe in 16-bit mode is shown by reading back a known high capture value that the strobe would otherwise overwrite.

// File: rtl/timerPkg.sv
package timerPkg;

  typedef enum logic [1:0] {
    MODE_SPLIT      = 2'd0,
    MODE_MIXED      = 2'd1,
    MODE_WIDE_TIMER = 2'd2,
    MODE_WIDE_EVENT = 2'd3
  } timerMode_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic incLo;
    logic incHi;
    logic wide;
    logic capLo;
    logic capHi;
    logic restart;
    logic clrLo;
    logic clrHi;
  } timerStb_t;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] REG_PRESCALE = 3'd1;
  localparam logic [ADDR_W-1:0] REG_MATCH_LO = 3'd2;
  localparam logic [ADDR_W-1:0] REG_MATCH_HI = 3'd3;
  localparam logic [ADDR_W-1:0] REG_COUNT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] REG_COUNT_HI = 3'd5;
  localparam logic [ADDR_W-1:0] REG_CAPT_LO  = 3'd6;
  localparam logic [ADDR_W-1:0] REG_CAPT_HI  = 3'd7;

  localparam int CTRL_RUN     = 2;
  localparam int CTRL_RESTART = 3;
  localparam int CTRL_CLR_LO  = 4;
  localparam int CTRL_CLR_HI  = 5;
  localparam int CTRL_FLAG_LO = 6;
  localparam int CTRL_FLAG_HI = 7;

endpackage

// File: rtl/timerSyncEdge.sv
module timerSyncEdge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);

  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/timerCtrl.sv
module timerCtrl
  import timerPkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [HALF_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [HALF_W-1:0] rdData,
  input  logic              evtIn,
  input  logic              capLoIn,
  input  logic              capHiIn,
  input  logic [HALF_W-1:0] cntLo,
  input  logic [HALF_W-1:0] cntHi,
  input  logic [HALF_W-1:0] capLoVal,
  input  logic [HALF_W-1:0] capHiVal,
  input  logic              flagLo,
  input  logic              flagHi,
  output timerStb_t         stb,
  output timerMode_e        mode,
  output logic              run,
  output logic [HALF_W-1:0] matchLo,
  output logic [HALF_W-1:0] matchHi
);

  localparam int N_SYNC    = 3;
  localparam int IDX_EVT   = 0;
  localparam int IDX_CAPLO = 1;
  localparam int IDX_CAPHI = 2;

  logic [N_SYNC-1:0] rawIn;
  logic [N_SYNC-1:0] rises;

  assign rawIn = {capHiIn, capLoIn, evtIn};

  generate
    for (genvar g = 0; g < N_SYNC; g++) begin : gSync
      timerSyncEdge #(.STAGES(SYNC_STAGES)) uSync (
        .clk  (clk),
        .rstN (rstN),
        .din  (rawIn[g]),
        .rise (rises[g])
      );
    end
  endgenerate

  logic ctrlWr;
  logic restartReq;
  logic evtRise;

  assign ctrlWr     = wrEn && (wrAddr == REG_CTRL);
  assign restartReq = ctrlWr && wrData[CTRL_RESTART];
  assign evtRise    = rises[IDX_EVT];

  logic [HALF_W-1:0] psPending;
  logic [HALF_W-1:0] psActive;
  logic [HALF_W-1:0] psCnt;
  logic              psTc;

  // Software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_SPLIT;
      run       <= 1'b0;
      psPending <= '0;
      matchLo   <= '1;
      matchHi   <= '1;
    end else if (wrEn) begin
      case (wrAddr)
        REG_CTRL: begin
          mode <= timerMode_e'(wrData[1:0]);
          run  <= wrData[CTRL_RUN];
        end
        REG_PRESCALE: psPending <= wrData;
        REG_MATCH_LO: matchLo   <= wrData;
        REG_MATCH_HI: matchHi   <= wrData;
        default: ;
      endcase
    end
  end

  // Prescaler: the new reload value is adopted at terminal count or restart
  assign psTc = run && (psCnt == psActive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt    <= '0;
      psActive <= '0;
    end else if (restartReq) begin
      psCnt    <= '0;
      psActive <= psPending;
    end else if (psTc) begin
      psCnt    <= '0;
      psActive <= psPending;
    end else if (run) begin
      psCnt    <= psCnt + 1'b1;
    end
  end

  // Route the counting sources according to the mode
  always_comb begin
    stb         = '0;
    stb.wide    = mode[1];
    stb.restart = restartReq;
    stb.clrLo   = ctrlWr && wrData[CTRL_CLR_LO];
    stb.clrHi   = ctrlWr && wrData[CTRL_CLR_HI];
    stb.capLo   = rises[IDX_CAPLO];
    stb.capHi   = rises[IDX_CAPHI] && !mode[1];
    case (mode)
      MODE_SPLIT: begin
        stb.incLo = psTc;
        stb.incHi = psTc;
      end
      MODE_MIXED: begin
        stb.incLo = psTc;
        stb.incHi = run && evtRise;
      end
      MODE_WIDE_TIMER: stb.incLo = psTc;
      MODE_WIDE_EVENT: stb.incLo = run && evtRise;
      default: ;
    endcase
  end

  // Combinational read port
  always_comb begin
    rdData = '0;
    case (rdAddr)
      REG_CTRL: begin
        rdData[1:0]          = mode;
        rdData[CTRL_RUN]     = run;
        rdData[CTRL_FLAG_LO] = flagLo;
        rdData[CTRL_FLAG_HI] = flagHi;
      end
      REG_PRESCALE: rdData = psPending;
      REG_MATCH_LO: rdData = matchLo;
      REG_MATCH_HI: rdData = matchHi;
      REG_COUNT_LO: rdData = cntLo;
      REG_COUNT_HI: rdData = cntHi;
      REG_CAPT_LO:  rdData = capLoVal;
      REG_CAPT_HI:  rdData = capHiVal;
      default: ;
    endcase
  end

endmodule

// File: rtl/timerDatapath.sv
module timerDatapath
  import timerPkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  timerStb_t         stb,
  input  logic [HALF_W-1:0] matchLo,
  input  logic [HALF_W-1:0] matchHi,
  output logic [HALF_W-1:0] cntLo,
  output logic [HALF_W-1:0] cntHi,
  output logic [HALF_W-1:0] capLoVal,
  output logic [HALF_W-1:0] capHiVal,
  output logic              flagLo,
  output logic              flagHi
);

  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] cntFull;
  logic [FULL_W-1:0] matchFull;
  logic              loHit;
  logic              hiHit;
  logic              wideHit;
  logic              setLo;
  logic              setHi;

  assign cntFull   = {cntHi, cntLo};
  assign matchFull = {matchHi, matchLo};
  assign loHit     = (cntLo == matchLo);
  assign hiHit     = (cntHi == matchHi);
  assign wideHit   = (cntFull == matchFull);

  assign setLo = !stb.restart && !stb.wide && stb.incLo && loHit;
  assign setHi = !stb.restart &&
                 (stb.wide ? (stb.incLo && wideHit) : (stb.incHi && hiHit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
    end else if (stb.restart) begin
      cntLo <= '0;
      cntHi <= '0;
    end else if (stb.wide) begin
      if (stb.incLo) {cntHi, cntLo} <= wideHit ? '0 : cntFull + 1'b1;
    end else begin
      if (stb.incLo) cntLo <= loHit ? '0 : cntLo + 1'b1;
      if (stb.incHi) cntHi <= hiHit ? '0 : cntHi + 1'b1;
    end
  end

  // A set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagLo <= 1'b0;
      flagHi <= 1'b0;
    end else begin
      flagLo <= setLo | (flagLo & ~stb.clrLo);
      flagHi <= setHi | (flagHi & ~stb.clrHi);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capLoVal <= '0;
      capHiVal <= '0;
    end else begin
      if (stb.capLo) begin
        capLoVal <= cntLo;
        if (stb.wide) capHiVal <= cntHi;
      end
      if (stb.capHi) capHiVal <= cntHi;
    end
  end

endmodule

// File: rtl/multiModeTimer.sv
module multiModeTimer
  import timerPkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [HALF_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [HALF_W-1:0] rdData,
  input  logic              evtIn,
  input  logic              capLoIn,
  input  logic              capHiIn,
  output logic              irqLo,
  output logic              irqHi
);

  timerStb_t         stb;
  timerMode_e        mode;
  logic              run;
  logic [HALF_W-1:0] matchLo;
  logic [HALF_W-1:0] matchHi;
  logic [HALF_W-1:0] cntLo;
  logic [HALF_W-1:0] cntHi;
  logic [HALF_W-1:0] capLoVal;
  logic [HALF_W-1:0] capHiVal;
  logic              flagLo;
  logic              flagHi;

  timerCtrl #(.HALF_W(HALF_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .evtIn    (evtIn),
    .capLoIn  (capLoIn),
    .capHiIn  (capHiIn),
    .cntLo    (cntLo),
    .cntHi    (cntHi),
    .capLoVal (capLoVal),
    .capHiVal (capHiVal),
    .flagLo   (flagLo),
    .flagHi   (flagHi),
    .stb      (stb),
    .mode     (mode),
    .run      (run),
    .matchLo  (matchLo),
    .matchHi  (matchHi)
  );

  timerDatapath #(.HALF_W(HALF_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .matchLo  (matchLo),
    .matchHi  (matchHi),
    .cntLo    (cntLo),
    .cntHi    (cntHi),
    .capLoVal (capLoVal),
    .capHiVal (capHiVal),
    .flagLo   (flagLo),
    .flagHi   (flagHi)
  );

  assign irqLo = flagLo;
  assign irqHi = flagHi;

endmodule

// File: rtl/timerChecker.sv
module timerChecker #(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        wrAddr,
  input logic [HALF_W-1:0] wrData,
  input logic [1:0]        modeBits,
  input logic              run,
  input logic [HALF_W-1:0] cntLo,
  input logic [HALF_W-1:0] cntHi,
  input logic [HALF_W-1:0] matchLo,
  input logic [HALF_W-1:0] matchHi,
  input logic              irqLo,
  input logic              irqHi
);

  logic ctrlWr;
  logic restartWr;
  logic clrLoWr;
  logic clrHiWr;

  assign ctrlWr    = wrEn && (wrAddr == 3'd0);
  assign restartWr = ctrlWr && wrData[3];
  assign clrLoWr   = ctrlWr && wrData[4];
  assign clrHiWr   = ctrlWr && wrData[5];

  assert_restart_clears_R13: assert property (@(posedge clk) disable iff (!rstN)
    restartWr |=> (cntLo == '0 && cntHi == '0));

  assert_frozen_when_stopped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !restartWr) |=> ($stable(cntLo) && $stable(cntHi)));

  assert_lo_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cntLo != $past(cntLo)) |-> (cntLo == $past(cntLo) + 1'b1 || cntLo == '0));

  assert_lo_flag_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLo) |-> $past(cntLo == matchLo && !modeBits[1]));

  assert_hi_flag_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqHi) |-> $past(modeBits[1] ? ({cntHi, cntLo} == {matchHi, matchLo})
                                       : (cntHi == matchHi)));

  assert_lo_flag_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqLo) |-> $past(clrLoWr));

  assert_hi_flag_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqHi) |-> $past(clrHiWr));

endmodule

bind multiModeTimer timerChecker #(.HALF_W(HALF_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .modeBits (mode),
  .run      (run),
  .cntLo    (cntLo),
  .cntHi    (cntHi),
  .matchLo  (matchLo),
  .matchHi  (matchHi),
  .irqLo    (irqLo),
  .irqHi    (irqHi)
);

// File: tb/multiModeTimer_test.sv
module multiModeTimer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       evtIn = 1'b0;
  logic       capLoIn = 1'b0;
  logic       capHiIn = 1'b0;
  logic       irqLo;
  logic       irqHi;

  int checks = 0;
  int fails  = 0;

  multiModeTimer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn), .capLoIn(capLoIn),
    .capHiIn(capHiIn), .irqLo(irqLo), .irqHi(irqHi)
  );

  always #10 clk = ~clk;

  // Fields: mode[41:40] prescale[39:32] matchLo[31:24] matchHi[23:16] cycles[15:0]
  localparam int NVEC = 7;
  localparam logic [41:0] VEC [NVEC] = '{
    {2'd0, 8'd0,   8'd4,   8'd9,   16'd11},
    {2'd0, 8'd2,   8'd255, 8'd3,   16'd29},
    {2'd2, 8'd0,   8'h05,  8'h01,  16'd299},
    {2'd2, 8'd1,   8'hFF,  8'hFF,  16'd599},
    {2'd1, 8'd3,   8'd2,   8'd7,   16'd40},
    {2'd0, 8'd255, 8'd1,   8'd1,   16'd100},
    {2'd3, 8'd0,   8'd0,   8'd0,   16'd50}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    wrAddr = a;
    wrData = d;
    wrEn   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output int v);
    rdAddr = a;
    #1;
    v = int'(rdData);
  endtask

  task automatic readCheck(input string tag, input logic [2:0] a, input int exp);
    int v;
    regRead(a, v);
    check(tag, v, exp);
  endtask

  task automatic evtPulse(input int hi, input int lo);
    evtIn = 1'b1; idle(hi);
    evtIn = 1'b0; idle(lo);
  endtask

  task automatic capLoPulse();
    capLoIn = 1'b1; idle(2);
    capLoIn = 1'b0; idle(5);
  endtask

  task automatic capHiPulse();
    capHiIn = 1'b1; idle(2);
    capHiIn = 1'b0; idle(5);
  endtask

  // Start: clear both flags, restart, run, mode
  task automatic startRun(input logic [1:0] m);
    regWrite(3'd0, 8'h3C | {6'd0, m});
  endtask

  task automatic applyVector(input logic [41:0] v);
    logic [1:0] m;
    int ps, mLo, mHi, k, t, full, c, expLo, expHi, expFl, expFh;
    string tag;
    m   = v[41:40];
    ps  = int'(v[39:32]);
    mLo = int'(v[31:24]);
    mHi = int'(v[23:16]);
    k   = int'(v[15:0]);
    regWrite(3'd1, v[39:32]);
    regWrite(3'd2, v[31:24]);
    regWrite(3'd3, v[23:16]);
    startRun(m);
    idle(k);
    regWrite(3'd0, {6'd0, m});
    t = (k + 1) / (ps + 1);
    expLo = 0; expHi = 0; expFl = 0; expFh = 0;
    case (m)
      2'd0: begin
        tag = "R5/R3";
        expLo = t % (mLo + 1); expFl = (t >= mLo + 1) ? 1 : 0;
        expHi = t % (mHi + 1); expFh = (t >= mHi + 1) ? 1 : 0;
      end
      2'd1: begin
        tag = "R6/R3";
        expLo = t % (mLo + 1); expFl = (t >= mLo + 1) ? 1 : 0;
      end
      2'd2: begin
        tag = "R7/R3";
        full = mHi * 256 + mLo;
        c = t % (full + 1);
        expLo = c % 256; expHi = c / 256;
        expFh = (t >= full + 1) ? 1 : 0;
      end
      default: tag = "R8";
    endcase
    readCheck(tag, 3'd4, expLo);
    readCheck(tag, 3'd5, expHi);
    check(tag, int'(irqLo), expFl);
    check(tag, int'(irqHi), expFh);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    readCheck("R1", 3'd0, 0);
    readCheck("R1", 3'd1, 0);
    readCheck("R1", 3'd2, 8'hFF);
    readCheck("R1", 3'd3, 8'hFF);
    readCheck("R1", 3'd4, 0);
    readCheck("R1", 3'd5, 0);
    readCheck("R1", 3'd6, 0);
    readCheck("R1", 3'd7, 0);
    check("R1", int'(irqLo), 0);
    check("R1", int'(irqHi), 0);

    // R2: register map and control encoding
    regWrite(3'd1, 8'h5A);
    readCheck("R2", 3'd1, 8'h5A);
    regWrite(3'd2, 8'h33);
    readCheck("R2", 3'd2, 8'h33);
    regWrite(3'd3, 8'hC4);
    readCheck("R2", 3'd3, 8'hC4);
    regWrite(3'd0, 8'h0D);
    readCheck("R2", 3'd0, 8'h05);
    regWrite(3'd0, 8'h00);

    // Vector table
    for (int i = 0; i < NVEC; i++) applyVector(VEC[i]);

    // R12, R13 and R3 stop behaviour after a mode 0 run with both flags set
    applyVector(VEC[0]);
    idle(20);
    readCheck("R3", 3'd4, 2);
    readCheck("R3", 3'd5, 2);
    regWrite(3'd0, 8'h10);
    check("R12", int'(irqLo), 0);
    check("R12", int'(irqHi), 1);
    readCheck("R12", 3'd0, 8'h80);
    regWrite(3'd0, 8'h20);
    check("R12", int'(irqHi), 0);
    regWrite(3'd0, 8'h08);
    readCheck("R13", 3'd4, 0);
    readCheck("R13", 3'd5, 0);

    // R4: reload written mid-period is deferred to the terminal count
    regWrite(3'd1, 8'd3);
    regWrite(3'd2, 8'hFF);
    regWrite(3'd3, 8'hFF);
    startRun(2'd0);
    idle(1);
    regWrite(3'd1, 8'd0);
    idle(5);
    regWrite(3'd0, 8'h00);
    readCheck("R4", 3'd4, 5);
    readCheck("R4", 3'd5, 5);

    // R6 and R9: event edges feed the high half in mode 1
    regWrite(3'd1, 8'hFF);
    startRun(2'd1);
    evtPulse(1, 1);
    evtPulse(1, 1);
    evtPulse(1, 1);
    evtPulse(10, 4);
    idle(4);
    regWrite(3'd0, 8'h01);
    readCheck("R9", 3'd5, 4);
    readCheck("R6", 3'd4, 0);

    // R8: 16-bit event counter wraps at its match, prescaler unused
    regWrite(3'd1, 8'd0);
    regWrite(3'd2, 8'd2);
    regWrite(3'd3, 8'd0);
    startRun(2'd3);
    for (int p = 0; p < 5; p++) evtPulse(2, 2);
    idle(30);
    regWrite(3'd0, 8'h03);
    readCheck("R8", 3'd4, 2);
    readCheck("R8", 3'd5, 0);
    check("R8", int'(irqHi), 1);
    check("R8", int'(irqLo), 0);

    // R10: per-half capture in split mode
    regWrite(3'd2, 8'hFF);
    regWrite(3'd3, 8'd3);
    startRun(2'd0);
    idle(9);
    regWrite(3'd0, 8'h00);
    capLoPulse();
    readCheck("R10", 3'd6, 8'h0A);
    readCheck("R10", 3'd7, 0);
    capHiPulse();
    readCheck("R10", 3'd7, 2);
    readCheck("R10", 3'd6, 8'h0A);

    // R11: 16-bit capture through the low strobe, high strobe ignored
    regWrite(3'd2, 8'hFF);
    regWrite(3'd3, 8'hFF);
    startRun(2'd2);
    idle(299);
    regWrite(3'd0, 8'h02);
    capLoPulse();
    readCheck("R11", 3'd6, 8'h2C);
    readCheck("R11", 3'd7, 8'h01);
    regWrite(3'd0, 8'h0A);
    readCheck("R13", 3'd5, 0);
    capHiPulse();
    readCheck("R11", 3'd7, 8'h01);
    readCheck("R11", 3'd6, 8'h2C);

    summary();
    $finish;
  end

endmodule